// File: doc/BRIEF.md
# Single-Bus Microcoded Memory-to-Memory Sequencer

This block is a small microcoded processor core. Every datapath register sits on one shared bus: a program counter, a register file of pointer registers, an instruction register, two operand latches (A and B), a memory-address latch and an adder. The core runs memory-to-memory instructions. A micro-program store decodes the current micro-address into one control word per cycle. That word holds one enable bit per bus source, load enables, register-file and memory enable and write bits, the adder operation, and a micro-branch code with a jump target.

Two instructions do real work. The three-operand add reads two memory words through pointer registers, adds them and writes the sum through a third pointer. The string copy moves words from a source pointer to a destination pointer. It stops after copying a zero word. Both run entirely as micro-op sequences. A conditional micro-branch on a zero B latch ends the copy loop. Any other opcode is fetched and then ignored.

Memory sits outside the block, on a word-addressed port with one cycle of read latency. A read is launched in the micro-cycle that loads the address latch, and its data drives the bus in the next micro-cycle. Pointers and the program counter hold byte addresses.

Top module: `ubus_seq`

## Requirements
- R1: A synchronous active-high `rst` puts the micro-address at fetch and the program counter at `RESET_PC`, and sets register i to i*`REG_STRIDE`. While reset is held, `mem_we` is 0 and `mem_addr` shows the reset program counter's word.
- R2: An instruction word has the opcode in bits [31:28], rd in bits [16 +: log2(NREG)], rs1 in bits [8 +: log2(NREG)] and rs2 in bits [0 +: log2(NREG)]. Opcode 1 is the add and opcode 2 is the copy. Every other opcode takes only the 3 fetch cycles and writes nothing.
- R3: Fetch takes 3 micro-cycles. It reads the word at the program counter into the instruction fields and advances the program counter by 4.
- R4: The add writes M[R[rd]] = M[R[rs1]] + M[R[rs2]] modulo 2^DW, in cycle 8 counted from its first fetch cycle (cycle 0). The next fetch starts in cycle 9.
- R5: Pointers are byte addresses. The memory port carries byte-address bits [AW+1:2].
- R6: The copy writes M[R[rd]] = M[R[rs1]] once per word. Iteration k starts in cycle 3+8k and does its write in cycle 6+8k.
- R7: The copy ends right after writing a zero word, and that last iteration lasts 5 cycles. The source and destination pointers each advance by 4 for every nonzero word and do not advance for the zero word.
- R8: Exactly one source drives the shared bus in every micro-cycle.
- R9: The memory write strobe is only raised with the memory enable, and the register write only with the register-file enable.
- R10: The instruction fields are only reloaded in the fetch cycle that takes the read data. They stay constant through the rest of an instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mem_en | output | 1 | Memory access enable (read when `mem_we` is 0) |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | AW | Word address |
| mem_wdata | output | DW | Write data (the bus value) |
| mem_rdata | input | DW | Read data, valid the cycle after the read is launched |

## Verification
The bench builds the block with DW=32, AW=8, NREG=8, REG_STRIDE=128 and RESET_PC=0. With these values every pointer register starts in its own 32-word region of a 256-word memory, away from the program at word 0. That lets one short program mix adds, an ignored opcode, an empty copy and a three-word copy with no overlap between regions. The program includes an add whose sum wraps past 2^32 and an add that reads and writes the same word. A later add reads through the pointers the copy has just advanced, which exposes how far they moved. Every expected write carries its exact cycle, so each micro-sequence length is checked as well as its data.

// File: rtl/ubus_pkg.sv
package ubus_pkg;

  localparam int UAW  = 5;
  localparam int NDRV = 5;

  // bus source enable bit positions
  localparam int DRV_PC  = 0;
  localparam int DRV_REG = 1;
  localparam int DRV_MEM = 2;
  localparam int DRV_ALU = 3;
  localparam int DRV_B   = 4;

  localparam logic [3:0] OP_ADDM = 4'h1;
  localparam logic [3:0] OP_SCPY = 4'h2;

  // micro-addresses the sequencer and checks refer to
  localparam logic [UAW-1:0] UA_F0       = 5'd0;
  localparam logic [UAW-1:0] UA_F1       = 5'd1;
  localparam logic [UAW-1:0] UA_F2       = 5'd2;
  localparam logic [UAW-1:0] UA_ADD      = 5'd3;
  localparam logic [UAW-1:0] UA_CPY      = 5'd9;
  localparam logic [UAW-1:0] UA_CPY_TEST = 5'd13;

  typedef enum logic [2:0] {
    UB_NEXT        = 3'd0,
    UB_JUMP        = 3'd1,
    UB_FETCH       = 3'd2,
    UB_FETCH_IF_BZ = 3'd3,
    UB_DISPATCH    = 3'd4
  } ubr_e;

  typedef enum logic [1:0] {
    RS_RD  = 2'd0,
    RS_RS1 = 2'd1,
    RS_RS2 = 2'd2
  } rsel_e;

  typedef enum logic {
    ALU_AB = 1'b0,
    ALU_A4 = 1'b1
  } alu_e;

  typedef struct packed {
    logic [NDRV-1:0] drv;
    logic            ld_ma;
    logic            ld_a;
    logic            ld_b;
    logic            ld_ir;
    logic            ld_pc;
    logic            reg_en;
    logic            reg_wr;
    rsel_e           rsel;
    logic            mem_en;
    logic            mem_wr;
    alu_e            alu;
    ubr_e            ubr;
    logic [UAW-1:0]  target;
  } uop_t;

endpackage

// File: rtl/ubus_urom.sv
module ubus_urom
  import ubus_pkg::*;
(
  input  logic [UAW-1:0] ua,
  output uop_t           uop
);

  // Fields that do not matter in a micro-op are left at 0.
  always_comb begin
    uop = '0;
    case (ua)
      // fetch
      5'd0: begin uop.drv[DRV_PC] = 1'b1; uop.ld_ma = 1'b1; uop.ld_a = 1'b1; uop.mem_en = 1'b1; end
      5'd1: begin uop.drv[DRV_MEM] = 1'b1; uop.ld_ir = 1'b1; end
      5'd2: begin uop.drv[DRV_ALU] = 1'b1; uop.alu = ALU_A4; uop.ld_pc = 1'b1; uop.ubr = UB_DISPATCH; end
      // memory-to-memory add
      5'd3: begin uop.drv[DRV_REG] = 1'b1; uop.reg_en = 1'b1; uop.rsel = RS_RS1; uop.ld_ma = 1'b1; uop.mem_en = 1'b1; end
      5'd4: begin uop.drv[DRV_MEM] = 1'b1; uop.ld_a = 1'b1; end
      5'd5: begin uop.drv[DRV_REG] = 1'b1; uop.reg_en = 1'b1; uop.rsel = RS_RS2; uop.ld_ma = 1'b1; uop.mem_en = 1'b1; end
      5'd6: begin uop.drv[DRV_MEM] = 1'b1; uop.ld_b = 1'b1; end
      5'd7: begin uop.drv[DRV_REG] = 1'b1; uop.reg_en = 1'b1; uop.rsel = RS_RD; uop.ld_ma = 1'b1; end
      5'd8: begin uop.drv[DRV_ALU] = 1'b1; uop.alu = ALU_AB; uop.mem_en = 1'b1; uop.mem_wr = 1'b1; uop.ubr = UB_FETCH; end
      // string copy loop
      5'd9:  begin uop.drv[DRV_REG] = 1'b1; uop.reg_en = 1'b1; uop.rsel = RS_RS1; uop.ld_ma = 1'b1; uop.ld_a = 1'b1; uop.mem_en = 1'b1; end
      5'd10: begin uop.drv[DRV_MEM] = 1'b1; uop.ld_b = 1'b1; end
      5'd11: begin uop.drv[DRV_REG] = 1'b1; uop.reg_en = 1'b1; uop.rsel = RS_RD; uop.ld_ma = 1'b1; end
      5'd12: begin uop.drv[DRV_B] = 1'b1; uop.mem_en = 1'b1; uop.mem_wr = 1'b1; end
      5'd13: begin uop.drv[DRV_B] = 1'b1; uop.ubr = UB_FETCH_IF_BZ; end
      5'd14: begin uop.drv[DRV_ALU] = 1'b1; uop.alu = ALU_A4; uop.reg_en = 1'b1; uop.reg_wr = 1'b1; uop.rsel = RS_RS1; end
      5'd15: begin uop.drv[DRV_REG] = 1'b1; uop.reg_en = 1'b1; uop.rsel = RS_RD; uop.ld_a = 1'b1; end
      5'd16: begin
        uop.drv[DRV_ALU] = 1'b1; uop.alu = ALU_A4; uop.reg_en = 1'b1; uop.reg_wr = 1'b1;
        uop.rsel = RS_RD; uop.ubr = UB_JUMP; uop.target = UA_CPY;
      end
      default: begin uop.drv[DRV_PC] = 1'b1; uop.ubr = UB_FETCH; end
    endcase
  end

endmodule

// File: rtl/ubus_useq.sv
module ubus_useq
  import ubus_pkg::*;
(
  input  logic           clk,
  input  logic           rst,
  input  ubr_e           ubr,
  input  logic [UAW-1:0] target,
  input  logic           b_zero,
  input  logic [3:0]     opcode,
  output logic [UAW-1:0] upc
);

  logic [UAW-1:0] seq_ua;
  logic [UAW-1:0] disp_ua;
  logic [UAW-1:0] nxt_ua;

  assign seq_ua = upc + UAW'(1);

  always_comb begin
    case (opcode)
      OP_ADDM: disp_ua = UA_ADD;
      OP_SCPY: disp_ua = UA_CPY;
      default: disp_ua = UA_F0;
    endcase
  end

  always_comb begin
    case (ubr)
      UB_NEXT:        nxt_ua = seq_ua;
      UB_JUMP:        nxt_ua = target;
      UB_FETCH:       nxt_ua = UA_F0;
      UB_FETCH_IF_BZ: nxt_ua = b_zero ? UA_F0 : seq_ua;
      UB_DISPATCH:    nxt_ua = disp_ua;
      default:        nxt_ua = UA_F0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) upc <= UA_F0;
    else     upc <= nxt_ua;
  end

  AST_COPY_EXIT_ON_ZERO: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_CPY_TEST && b_zero) |=> (upc == UA_F0)) else $error("copy did not exit on zero"); // R7

  AST_DISPATCH_TARGET: assert property (@(posedge clk) disable iff (rst)
    (upc == UA_F2) |=> (upc == UA_F0 || upc == UA_ADD || upc == UA_CPY)) else $error("bad dispatch"); // R2

endmodule

// File: rtl/ubus_regfile.sv
module ubus_regfile #(
  parameter int DW     = 32,
  parameter int NREG   = 8,
  parameter int RW     = 3,
  parameter int STRIDE = 128
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [RW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] rv [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk) begin
      if (rst)                         q <= DW'(i * STRIDE);
      else if (we && idx == RW'(i))    q <= wdata;
    end
    assign rv[i] = q;
  end

  assign rdata = rv[idx];

endmodule

// File: rtl/ubus_seq.sv
module ubus_seq
  import ubus_pkg::*;
#(
  parameter int DW         = 32,
  parameter int AW         = 8,
  parameter int NREG       = 8,
  parameter int RESET_PC   = 0,
  parameter int REG_STRIDE = 128
) (
  input  logic          clk,
  input  logic          rst,
  output logic          mem_en,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata
);

  localparam int RW = $clog2(NREG);

  uop_t           uop;
  logic [UAW-1:0] upc;
  logic [DW-1:0]  bus;
  logic [DW-1:0]  pc, a_q, b_q, alu_y, rf_rdata;
  logic [AW-1:0]  ma_q;
  logic [3:0]     ir_op;
  logic [RW-1:0]  ir_rd, ir_rs1, ir_rs2, rf_idx;
  logic           b_zero;

  ubus_urom u_rom (.ua(upc), .uop(uop));

  ubus_useq u_seq (
    .clk(clk), .rst(rst), .ubr(uop.ubr), .target(uop.target),
    .b_zero(b_zero), .opcode(ir_op), .upc(upc)
  );

  always_comb begin
    case (uop.rsel)
      RS_RS1:  rf_idx = ir_rs1;
      RS_RS2:  rf_idx = ir_rs2;
      default: rf_idx = ir_rd;
    endcase
  end

  ubus_regfile #(.DW(DW), .NREG(NREG), .RW(RW), .STRIDE(REG_STRIDE)) u_rf (
    .clk(clk), .rst(rst), .we(uop.reg_wr), .idx(rf_idx), .wdata(bus), .rdata(rf_rdata)
  );

  assign alu_y = a_q + ((uop.alu == ALU_AB) ? b_q : DW'(4));

  // shared bus: AND-OR of the enabled sources
  always_comb begin
    bus = '0;
    if (uop.drv[DRV_PC])  bus = bus | pc;
    if (uop.drv[DRV_REG]) bus = bus | rf_rdata;
    if (uop.drv[DRV_MEM]) bus = bus | mem_rdata;
    if (uop.drv[DRV_ALU]) bus = bus | alu_y;
    if (uop.drv[DRV_B])   bus = bus | b_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc     <= DW'(RESET_PC);
      ma_q   <= '0;
      a_q    <= '0;
      b_q    <= '0;
      ir_op  <= '0;
      ir_rd  <= '0;
      ir_rs1 <= '0;
      ir_rs2 <= '0;
    end else begin
      if (uop.ld_pc) pc   <= bus;
      if (uop.ld_ma) ma_q <= bus[AW+1:2];
      if (uop.ld_a)  a_q  <= bus;
      if (uop.ld_b)  b_q  <= bus;
      if (uop.ld_ir) begin
        ir_op  <= bus[DW-1 -: 4];
        ir_rd  <= bus[16 +: RW];
        ir_rs1 <= bus[8 +: RW];
        ir_rs2 <= bus[0 +: RW];
      end
    end
  end

  assign b_zero    = (b_q == '0);
  assign mem_en    = uop.mem_en;
  assign mem_we    = uop.mem_wr;
  // a read is launched in the same cycle that loads the address latch
  assign mem_addr  = uop.ld_ma ? bus[AW+1:2] : ma_q;
  assign mem_wdata = bus;

  AST_BUS_ONE_DRIVER: assert property (@(posedge clk) disable iff (rst)
    $countones(uop.drv) == 1) else $error("bus driver count"); // R8

  AST_MEM_WE_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> mem_en) else $error("write without enable"); // R9

  AST_REG_WR_NEEDS_EN: assert property (@(posedge clk) disable iff (rst)
    uop.reg_wr |-> uop.reg_en) else $error("reg write without enable"); // R9

  AST_IR_ONLY_IN_FETCH: assert property (@(posedge clk) disable iff (rst)
    uop.ld_ir |-> (upc == UA_F1)) else $error("instruction reload mid-op"); // R10

  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    uop.ld_pc |=> (pc == $past(pc) + DW'(4))) else $error("pc step"); // R3

endmodule

// File: tb/sim_ubus_seq.sv
`timescale 1ns/1ps
module sim_ubus_seq;

  localparam int DW = 32;
  localparam int AW = 8;
  localparam int NREG = 8;
  localparam int STRIDE = 128;
  localparam int NW = 1 << AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic          mem_en, mem_we;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata;
  logic [DW-1:0] mem_rdata;

  ubus_seq #(.DW(DW), .AW(AW), .NREG(NREG), .RESET_PC(0), .REG_STRIDE(STRIDE)) u0 (
    .clk(clk), .rst(rst), .mem_en(mem_en), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  logic [DW-1:0] ram   [NW];
  logic [DW-1:0] ref_m [NW];
  logic [DW-1:0] rr    [NREG];
  int rcyc, rpc, cyc, errors, checks;
  bit done;

  typedef struct {
    int          cyc;
    int          addr;
    logic [31:0] data;
    string       tag;
  } exp_t;
  exp_t q[$];

  always @(posedge clk) begin
    if (mem_en) begin
      if (mem_we) ram[mem_addr] <= mem_wdata;
      else        mem_rdata <= ram[mem_addr];
    end
  end

  always @(posedge clk) begin
    if (rst) cyc <= 0;
    else     cyc <= cyc + 1;
  end

  function automatic int widx(logic [DW-1:0] p);
    return int'(p[AW+1:2]);
  endfunction

  task automatic put_instr(logic [3:0] op, int rd, int rs1, int rs2);
    logic [DW-1:0] w;
    w = {op, 4'h0, 8'(rd), 8'(rs1), 8'(rs2)};
    ram[rpc >> 2] = w;
    ref_m[rpc >> 2] = w;
    rpc += 4;
  endtask

  // driver tasks: place the instruction and push the writes it must produce
  task automatic drv_addm(int rd, int rs1, int rs2, string tag);
    logic [DW-1:0] s;
    int w;
    put_instr(4'h1, rd, rs1, rs2);
    s = ref_m[widx(rr[rs1])] + ref_m[widx(rr[rs2])];
    w = widx(rr[rd]);
    ref_m[w] = s;
    q.push_back('{rcyc + 8, w, s, tag});
    rcyc += 9;
  endtask

  task automatic drv_scpy(int rd, int rs, string tag);
    logic [DW-1:0] v;
    int w, k;
    put_instr(4'h2, rd, rs, 0);
    k = 0;
    while (1) begin
      v = ref_m[widx(rr[rs])];
      w = widx(rr[rd]);
      q.push_back('{rcyc + 6 + 8 * k, w, v, tag});
      ref_m[w] = v;
      if (v == '0) break;
      rr[rs] += 4;
      rr[rd] += 4;
      k++;
    end
    rcyc += 8 * k + 8;
  endtask

  task automatic drv_nop();
    put_instr(4'hF, 1, 2, 3);
    rcyc += 3;
  endtask

  // monitor: pop and compare every write the design makes
  always @(negedge clk) begin
    if (!rst && mem_we) begin
      checks++;
      if (q.size() == 0) begin
        errors++;
        $display("FAIL R2: unexpected write cyc=%0d addr=%0d data=%h, expected no write", cyc, mem_addr, mem_wdata);
      end else begin
        exp_t e;
        e = q.pop_front();
        if (cyc != e.cyc || int'(mem_addr) != e.addr || mem_wdata != e.data || !mem_en) begin
          errors++;
          $display("FAIL %s: cyc=%0d addr=%0d data=%h en=%b, expected cyc=%0d addr=%0d data=%h en=1",
                   e.tag, cyc, mem_addr, mem_wdata, mem_en, e.cyc, e.addr, e.data);
        end
      end
    end
  end

  initial begin
    errors = 0; checks = 0; done = 0; rcyc = 0; rpc = 0;
    for (int i = 0; i < NW; i++) ram[i] = '0;
    ram[32]  = 32'h1111_1111;
    ram[64]  = 32'h2222_2222;
    ram[65]  = 32'h0000_0005;
    ram[66]  = 32'h0000_0ABC;
    ram[67]  = 32'h0000_0000;
    ram[68]  = 32'h0000_0007;
    ram[128] = 32'hFFFF_FFFF;
    ram[192] = 32'h0000_0002;
    ram[224] = 32'h0000_0000;
    ram[228] = 32'h0000_0009;
    for (int i = 0; i < NW; i++) ref_m[i] = ram[i];
    for (int i = 0; i < NREG; i++) rr[i] = DW'(i * STRIDE);

    drv_addm(3, 1, 2, "R4 R1 R3 R5 R8 R10");   // plain add
    drv_addm(1, 1, 1, "R4 R9 R10");            // same word read twice and rewritten
    drv_nop();                                 // ignored opcode
    drv_addm(5, 4, 6, "R4 R2 wrap");           // wraps past 2^32; start cycle proves nop length
    drv_scpy(6, 7, "R7 empty copy");           // zero first word
    drv_scpy(7, 2, "R6 R7 copy");              // three words then zero
    drv_addm(7, 2, 1, "R7 R5 pointer advance");

    repeat (3) @(posedge clk);
    @(negedge clk);
    checks++;
    if (mem_we !== 1'b0 || mem_addr !== '0) begin
      errors++;
      $display("FAIL R1: reset mem_we=%b mem_addr=%0d, expected mem_we=0 mem_addr=0", mem_we, mem_addr);
    end
    rst = 1'b0;
    while (q.size() != 0) @(negedge clk);
    repeat (40) @(negedge clk);
    checks++;
    if (q.size() != 0) begin
      errors++;
      $display("FAIL R6: %0d writes missing, expected 0", q.size());
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL R3: watchdog expired with %0d writes pending, expected 0", q.size());
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule